// File: doc/BRIEF.md
# Chained Two-Channel Timer Counter

This block joins two equal-width up-counting timer channels into one counter of twice the width. A shared prescaler produces a tick every `tick_div + 1` clocks, and the low channel advances on every tick once it has been started. The low channel drives a waveform signal, the carry. The carry goes high when the low count reaches compare value A and goes low when the count reaches compare value C. This signal is the only link into the high channel. Because the carry comes from the compare values and not from a fixed overflow line, software can move it at run time by rewriting A and C.

The high channel has two modes, chosen by `hi_mode`. In gated mode (`hi_mode = 0`) it advances on any tick where the carry is high, so both halves update on the same clock edge. In edge mode (`hi_mode = 1`) it advances one clock after each falling edge of the carry. The usual setting is A = all ones and C = zero. With that setting the carry is high only while the low count holds its maximum value, and the pair behaves as one wide counter. The first carry pulse after a start is counted like any other. The pair port returns both counts sampled on the same clock.

Top module: `chained_timer`

## Requirements
- R1: After reset, both counts are zero, the carry is low, and neither channel runs until its own start pulse arrives.
- R2: While the low channel runs, it advances by exactly one on each tick. A start of the low channel also restarts the prescaler, so the first advance comes `tick_div + 1` clocks after the start edge, and the next ones follow every `tick_div + 1` clocks.
- R3: Each channel wraps from its all-ones value to zero and keeps counting.
- R4: On a tick, when the new low count equals C, the carry becomes 0. Otherwise, when the new low count equals A, the carry becomes 1. Otherwise the carry keeps its value. When A equals C, clear wins, so the carry is never set.
- R5: In gated mode (`hi_mode = 0`), the high channel advances on the same tick as the low channel whenever the carry is high. This includes the first carry after start, so `{hi,lo}` goes from 0x0F to 0x10 in the 4-bit setup.
- R6: In edge mode (`hi_mode = 1`), the high channel advances exactly one clock after each falling edge of the carry, including the first falling edge after start. A falling edge caused by a low-channel start is not counted.
- R7: With A = all ones and C = 0 in gated mode, the combined count rolls over from all ones to zero.
- R8: A and C may be written while the low channel runs. A write takes effect at the first tick after the write edge.
- R9: A start pulse clears its channel's count to zero and sets it running. A low start also clears the carry. A channel that has not been started stays at zero.
- R10: `cnt_pair` always equals `{hi_count, lo_count}` from the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div | input | DIV_W | Prescaler limit; tick period is tick_div+1 clocks |
| lo_start | input | 1 | Start pulse for the low channel (also resyncs prescaler) |
| hi_start | input | 1 | Start pulse for the high channel |
| hi_mode | input | 1 | 0 = gated advance, 1 = falling-edge advance |
| cmp_a_we | input | 1 | Write enable for compare value A (set point) |
| cmp_c_we | input | 1 | Write enable for compare value C (clear point) |
| cmp_wdata | input | CNT_W | Data for compare writes |
| lo_count | output | CNT_W | Low channel count |
| hi_count | output | CNT_W | High channel count |
| cnt_pair | output | 2*CNT_W | Combined count {high, low} |
| carry_wave | output | 1 | Low channel waveform (carry) |

## Verification
The hardest case to reach from the ports is the very first carry after a start, in both modes. It must count exactly like the later ones. The full-wrap behaviour of the high half is also hard to reach, because at full width it needs billions of ticks. The bench therefore uses a 4-bit channel width and a small prescaler. It restarts both channels and sweeps more than a full rollover of the combined count, tick by tick. Every value is predicted from the number of elapsed clocks. The compare values are then retargeted in the middle of a run, first to an early point, then back to the wrap point, and then to equal A and C.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic {
    MODE_GATED = 1'b0,
    MODE_EDGE  = 1'b1
  } hi_mode_e;

  // Increment modulo 2**w (w <= 32)
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

  // Waveform update on a tick: clear beats set
  function automatic logic wave_step(input logic cur, input logic hit_set, input logic hit_clr);
    if (hit_clr)      return 1'b0;
    else if (hit_set) return 1'b1;
    else              return cur;
  endfunction

endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;

  assign tick = (pre_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (sync)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ctmr_low_channel.sv
module ctmr_low_channel
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             a_we,
  input  logic             c_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wave,
  output logic             run,
  output logic [CNT_W-1:0] cmp_c
);
  logic [CNT_W-1:0] cmp_a;
  logic [CNT_W-1:0] cnt_next;
  logic             hit_set, hit_clr;

  assign cnt_next = CNT_W'(wrap_inc(32'(cnt), CNT_W));
  assign hit_set  = (cnt_next == cmp_a);
  assign hit_clr  = (cnt_next == cmp_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '1;
      cmp_c <= '0;
    end else begin
      if (a_we) cmp_a <= wdata;
      if (c_we) cmp_c <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
      run  <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      wave <= 1'b0;
      run  <= 1'b1;
    end else if (run && tick) begin
      cnt  <= cnt_next;
      wave <= wave_step(wave, hit_set, hit_clr);
    end
  end
endmodule

// File: rtl/ctmr_high_channel.sv
module ctmr_high_channel
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             mode,
  input  logic             carry,
  input  logic             carry_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             adv
);
  logic carry_d;
  logic carry_fall;

  assign carry_fall = carry_d & ~carry;
  assign adv = run & ((hi_mode_e'(mode) == MODE_GATED) ? (tick & carry) : carry_fall);

  always_ff @(posedge clk) begin
    if (!rst_n)         carry_d <= 1'b0;
    else if (carry_clr) carry_d <= 1'b0;
    else                carry_d <= carry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (adv) begin
      cnt <= CNT_W'(wrap_inc(32'(cnt), CNT_W));
    end
  end
endmodule

// File: rtl/chained_timer.sv
module chained_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  localparam int PAIR_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  tick_div,
  input  logic              lo_start,
  input  logic              hi_start,
  input  logic              hi_mode,
  input  logic              cmp_a_we,
  input  logic              cmp_c_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  output logic [CNT_W-1:0]  lo_count,
  output logic [CNT_W-1:0]  hi_count,
  output logic [PAIR_W-1:0] cnt_pair,
  output logic              carry_wave
);
  logic             tick;
  logic             lo_run, hi_run, hi_adv;
  logic [CNT_W-1:0] cmp_c_q;

  ctmr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sync(lo_start), .div(tick_div), .tick(tick)
  );

  ctmr_low_channel #(.CNT_W(CNT_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(lo_start),
    .a_we(cmp_a_we), .c_we(cmp_c_we), .wdata(cmp_wdata),
    .cnt(lo_count), .wave(carry_wave), .run(lo_run), .cmp_c(cmp_c_q)
  );

  ctmr_high_channel #(.CNT_W(CNT_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(hi_start), .mode(hi_mode),
    .carry(carry_wave), .carry_clr(lo_start),
    .cnt(hi_count), .run(hi_run), .adv(hi_adv)
  );

  assign cnt_pair = {hi_count, lo_count};
endmodule

// File: rtl/chained_timer_chk.sv
module chained_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             lo_start,
  input logic             hi_start,
  input logic             hi_mode,
  input logic             lo_run,
  input logic             hi_run,
  input logic [CNT_W-1:0] lo_cnt,
  input logic [CNT_W-1:0] hi_cnt,
  input logic             wave,
  input logic [CNT_W-1:0] cmp_c
);
  p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run && tick && !lo_start) |=> lo_cnt == CNT_W'($past(lo_cnt) + 1'b1));

  p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lo_run && tick) && !lo_start) |=> $stable(lo_cnt));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run && tick && !lo_start && (CNT_W'(lo_cnt + 1'b1) == cmp_c)) |=> !wave);

  p_gated_same_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_mode && hi_run && tick && wave && !hi_start) |=> hi_cnt == CNT_W'($past(hi_cnt) + 1'b1));

  p_edge_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_mode && hi_run && !hi_start && $fell(wave) && !$past(lo_start))
      |=> hi_cnt == CNT_W'($past(hi_cnt) + 1'b1));

  p_lo_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_start |=> (lo_cnt == '0) && !wave);

  p_hi_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_start |=> hi_cnt == '0);

  p_hi_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_run |-> hi_cnt == '0);
endmodule

bind chained_timer chained_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .lo_start(lo_start), .hi_start(hi_start),
  .hi_mode(hi_mode), .lo_run(lo_run), .hi_run(hi_run), .lo_cnt(lo_count),
  .hi_cnt(hi_count), .wave(carry_wave), .cmp_c(cmp_c_q)
);

// File: tb/chained_timer_tb_top.sv
module chained_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 4;
  localparam int DW    = 4;
  localparam int LMOD  = 1 << W;
  localparam int PMOD  = 1 << (2 * W);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [DW-1:0]  tick_div;
  logic           lo_start, hi_start, hi_mode, cmp_a_we, cmp_c_we;
  logic [W-1:0]   cmp_wdata;
  logic [W-1:0]   lo_count, hi_count;
  logic [2*W-1:0] cnt_pair;
  logic           carry_wave;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  chained_timer #(.CNT_W(W), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .lo_start(lo_start),
    .hi_start(hi_start), .hi_mode(hi_mode), .cmp_a_we(cmp_a_we), .cmp_c_we(cmp_c_we),
    .cmp_wdata(cmp_wdata), .lo_count(lo_count), .hi_count(hi_count),
    .cnt_pair(cnt_pair), .carry_wave(carry_wave)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lo_start = 0; hi_start = 0; hi_mode = 0;
    cmp_a_we = 0; cmp_c_we = 0; cmp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // hi_start one edge, lo_start the next; returns at negedge with m = 0
  task automatic start_both();
    hi_start = 1'b1;
    @(negedge clk);
    hi_start = 1'b0; lo_start = 1'b1;
    @(negedge clk);
    lo_start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    tick_div = 4'd1;
    do_reset();
    // R1: reset state and idle before start
    chk("R1 lo", int'(lo_count), 0);
    chk("R1 hi", int'(hi_count), 0);
    chk("R1 carry", int'(carry_wave), 0);
    repeat (10) @(negedge clk);
    chk("R1 lo idle", int'(lo_count), 0);
    chk("R9 hi not started", int'(hi_count), 0);

    // Gated sweep, tick_div = 1, past full rollover (R2 R3 R5 R7 R10)
    hi_mode = 1'b0;
    start_both();
    for (int m = 0; m < 560; m++) begin
      int n, ep, el;
      n  = m / 2;
      ep = n % PMOD;
      el = n % LMOD;
      chk("R2 lo", int'(lo_count), el);
      chk("R4 carry", int'(carry_wave), (el == LMOD - 1) ? 1 : 0);
      chk("R10 pair", int'(cnt_pair), int'({hi_count, lo_count}));
      if (n > 0 && (n % PMOD) == 0)      chk("R7 rollover", int'(cnt_pair), ep);
      else if (n > 0 && el == 0)         chk("R5 R3 carry into hi", int'(cnt_pair), ep);
      else                               chk("R5 pair", int'(cnt_pair), ep);
      @(negedge clk);
    end

    // Edge mode sweep, tick_div = 2 (R6)
    tick_div = 4'd2;
    hi_mode  = 1'b1;
    start_both();
    for (int m = 0; m < 300; m++) begin
      int nl, nh;
      nl = m / 3;
      nh = (m == 0) ? 0 : ((m - 1) / 3) / LMOD;
      chk("R2 lo edge", int'(lo_count), nl % LMOD);
      chk("R6 hi edge", int'(hi_count), nh % LMOD);
      @(negedge clk);
    end

    // Compare retargeting, tick_div = 0, high channel left unstarted (R4 R8 R9)
    do_reset();
    tick_div  = 4'd0;
    cmp_a_we  = 1'b1; cmp_wdata = 4'd1;
    @(negedge clk);
    cmp_a_we  = 1'b0; cmp_c_we = 1'b1; cmp_wdata = 4'd2;
    @(negedge clk);
    cmp_c_we  = 1'b0;
    lo_start  = 1'b1;
    @(negedge clk);
    lo_start  = 1'b0;
    for (int m = 0; m < 120; m++) begin
      int el, ew;
      el = m % LMOD;
      if (m < 47)       ew = (el == 1) ? 1 : 0;
      else if (m < 81)  ew = (el == LMOD - 1) ? 1 : 0;
      else              ew = 0;
      if (m < 46)       chk("R4 early pulse", int'(carry_wave), ew);
      else if (m < 83)  chk("R8 retarget", int'(carry_wave), ew);
      else              chk("R4 clear wins", int'(carry_wave), ew);
      chk("R3 lo", int'(lo_count), el);
      chk("R9 hi unstarted", int'(hi_count), 0);
      cmp_a_we = 1'b0; cmp_c_we = 1'b0;
      if (m == 45) begin cmp_a_we = 1'b1; cmp_wdata = 4'd15; end
      if (m == 46) begin cmp_c_we = 1'b1; cmp_wdata = 4'd0;  end
      if (m == 81) begin cmp_a_we = 1'b1; cmp_wdata = 4'd7;  end
      if (m == 82) begin cmp_c_we = 1'b1; cmp_wdata = 4'd7;  end
      @(negedge clk);
    end
    cmp_a_we = 1'b0; cmp_c_we = 1'b0;

    // Restart while running (R9)
    cmp_a_we = 1'b1; cmp_wdata = 4'd3;
    @(negedge clk);
    cmp_a_we = 1'b0;
    repeat (20) @(negedge clk);
    hi_start = 1'b1; lo_start = 1'b1;
    @(negedge clk);
    hi_start = 1'b0; lo_start = 1'b0;
    chk("R9 lo cleared", int'(lo_count), 0);
    chk("R9 carry cleared", int'(carry_wave), 0);
    chk("R9 hi cleared", int'(hi_count), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule